// File: doc/BRIEF.md
# DMA Request Pulse Generator

This block turns buffer status events of a multi-channel serial controller into request strobes for an external DMA engine. Each channel owns a transmit-ready request and a receive-ready request, both active low. When the transmit buffer of a channel goes from occupied to empty, or a fresh character lands in its receive buffer, the matching request line is driven low for a fixed number of system clocks (three by default) and then released. Each request line has its own enable bit. The control register that holds these bits lives outside this block.

Requests are edge-triggered. A status level that stays active yields one strobe only. A strobe that has started always runs its full length. A new edge that arrives while the strobe is still low is dropped.

The receive path has one diversion. When a channel runs in first-character-only interrupt mode and a special receive condition is flagged as the character arrives, the receive request is suppressed. A sticky receiver interrupt request is raised in its place, so the CPU sees the break in the transfer. That interrupt stays set until software pulses the channel's clear input.

Top module: `dma_req_pulse_gen`

## Requirements
- R1: After reset every txRdyN and rxRdyN output is high and every rxIntReq bit is low.
- R2: When a clock edge samples txEmpty of a channel at 1, the previous edge sampled it at 0, and txReqEn of that channel is 1, that channel's txRdyN is low for exactly PULSE_LEN cycles (default 3), starting right after that edge.
- R3: When a clock edge samples rxAvail of a channel rising from 0 to 1 with rxReqEn set, and firstCharMode and specialCond are not both 1, that channel's rxRdyN is low for exactly PULSE_LEN cycles, starting right after that edge.
- R4: A rising edge that is sampled while the channel's enable bit is 0 produces no pulse, and the output stays high.
- R5: A condition that stays at 1 after its rising edge produces no further pulse.
- R6: A rising edge sampled while the same output is low (including its last low cycle) is ignored, and the running pulse is not lengthened. A rising edge sampled once the output is high again starts a new pulse.
- R7: When rxAvail rises while firstCharMode and specialCond of that channel are both 1, rxRdyN stays high, whatever rxReqEn is, and rxIntReq of that channel is 1 from the next cycle on.
- R8: specialCond has no effect while firstCharMode is 0: a normal rxRdyN pulse occurs and rxIntReq stays low.
- R9: rxIntReq stays at 1 until an edge samples rxIntClr at 1 and then reads 0. When a new diversion and a clear arrive on the same edge, the interrupt stays set.
- R10: Channels are independent. Events on one channel never move another channel's outputs, and two channels can pulse at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEmpty | input | NUM_CH | Per-channel transmit buffer empty level |
| rxAvail | input | NUM_CH | Per-channel receive character available level |
| txReqEn | input | NUM_CH | Per-channel transmit request enable |
| rxReqEn | input | NUM_CH | Per-channel receive request enable |
| firstCharMode | input | NUM_CH | Per-channel first-character-only interrupt mode |
| specialCond | input | NUM_CH | Per-channel special receive condition flag |
| rxIntClr | input | NUM_CH | Per-channel clear strobe for the receiver interrupt |
| txRdyN | output | NUM_CH | Active-low transmit-ready request pulse |
| rxRdyN | output | NUM_CH | Active-low receive-ready request pulse |
| rxIntReq | output | NUM_CH | Sticky receiver interrupt request |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that specialCond describes the character whose rxAvail edge is sampled on the same clock edge, so the diversion decision is made on that one edge only. The bench drives every input on the falling edge and holds it for a full cycle. It raises specialCond together with the receive edge and lowers every condition between trials, so each rising edge is clean. Retrigger sweeps drop a condition and raise it again at every offset inside and just past a pulse, which exercises the busy window from both sides.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic txFire;   // start a transmit request pulse
    logic rxFire;   // start a receive request pulse
    logic intSet;   // raise the receiver interrupt
  } chanStrobe_t;

endpackage

// File: rtl/dma_req_pulse_timer.sv
module dma_req_pulse_timer #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic pulseN
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (fire && remain == '0) begin
      remain <= LOAD_VAL;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign pulseN = (remain == '0);

  // Independent run-length monitor of the output level
  logic [CNT_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (pulseN) lowRun <= '0;
    else lowRun <= lowRun + 1'b1;
  end

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    !pulseN |-> lowRun < LOAD_VAL) else $error("pulse too long"); // R6
  AST_PULSE_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseN) |-> lowRun == LOAD_VAL) else $error("pulse cut short"); // R2

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        txEmpty,
  input  logic [NUM_CH-1:0]        rxAvail,
  input  logic [NUM_CH-1:0]        txReqEn,
  input  logic [NUM_CH-1:0]        rxReqEn,
  input  logic [NUM_CH-1:0]        firstCharMode,
  input  logic [NUM_CH-1:0]        specialCond,
  input  logic [NUM_CH-1:0]        txRdyN,
  input  logic [NUM_CH-1:0]        rxRdyN,
  output chanStrobe_t [NUM_CH-1:0] strobe
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic txPrev, rxPrev;
    logic txRise, rxRise, divert;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txPrev <= 1'b0;
        rxPrev <= 1'b0;
      end else begin
        txPrev <= txEmpty[ch];
        rxPrev <= rxAvail[ch];
      end
    end

    assign txRise = txEmpty[ch] & ~txPrev;
    assign rxRise = rxAvail[ch] & ~rxPrev;
    assign divert = firstCharMode[ch] & specialCond[ch];

    // A request is started only while the same output is idle
    assign strobe[ch].txFire = txRise & txReqEn[ch] & txRdyN[ch];
    assign strobe[ch].rxFire = rxRise & rxReqEn[ch] & ~divert & rxRdyN[ch];
    assign strobe[ch].intSet = rxRise & divert;

    AST_TX_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(txRdyN[ch]) |-> $past(txReqEn[ch] && txEmpty[ch])) else $error("tx cause"); // R4
    AST_RX_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rxRdyN[ch]) |-> $past(rxReqEn[ch] && rxAvail[ch]
                                  && !(firstCharMode[ch] && specialCond[ch]))) else $error("rx cause"); // R7
    AST_RX_DIVERT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[ch].intSet && rxRdyN[ch]) |=> rxRdyN[ch]) else $error("diverted rx pulsed"); // R7
    AST_TX_HELD_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(txEmpty[ch]) && txEmpty[ch] && txRdyN[ch] && $past(txRdyN[ch])) |=> txRdyN[ch])
      else $error("held level retriggered"); // R5
  end

endmodule

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int PULSE_LEN = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chanStrobe_t [NUM_CH-1:0] strobe,
  input  logic [NUM_CH-1:0]        rxIntClr,
  output logic [NUM_CH-1:0]        txRdyN,
  output logic [NUM_CH-1:0]        rxRdyN,
  output logic [NUM_CH-1:0]        rxIntReq
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dma_req_pulse_timer #(.PULSE_LEN(PULSE_LEN)) txTimer_i (
      .clk    (clk),
      .rstN   (rstN),
      .fire   (strobe[ch].txFire),
      .pulseN (txRdyN[ch])
    );

    dma_req_pulse_timer #(.PULSE_LEN(PULSE_LEN)) rxTimer_i (
      .clk    (clk),
      .rstN   (rstN),
      .fire   (strobe[ch].rxFire),
      .pulseN (rxRdyN[ch])
    );

    // Sticky interrupt flag; a new set outranks a clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rxIntReq[ch] <= 1'b0;
      else if (strobe[ch].intSet) rxIntReq[ch] <= 1'b1;
      else if (rxIntClr[ch]) rxIntReq[ch] <= 1'b0;
    end

    AST_INT_SET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rxIntReq[ch]) |-> $past(strobe[ch].intSet)) else $error("spurious int"); // R7
    AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (rxIntReq[ch] && !rxIntClr[ch]) |=> rxIntReq[ch]) else $error("int lost"); // R9
    AST_INT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      (rxIntClr[ch] && !strobe[ch].intSet) |=> !rxIntReq[ch]) else $error("int not cleared"); // R9
  end

endmodule

// File: rtl/dma_req_pulse_gen.sv
module dma_req_pulse_gen
  import dma_req_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int PULSE_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] txEmpty,
  input  logic [NUM_CH-1:0] rxAvail,
  input  logic [NUM_CH-1:0] txReqEn,
  input  logic [NUM_CH-1:0] rxReqEn,
  input  logic [NUM_CH-1:0] firstCharMode,
  input  logic [NUM_CH-1:0] specialCond,
  input  logic [NUM_CH-1:0] rxIntClr,
  output logic [NUM_CH-1:0] txRdyN,
  output logic [NUM_CH-1:0] rxRdyN,
  output logic [NUM_CH-1:0] rxIntReq
);

  chanStrobe_t [NUM_CH-1:0] strobe;

  dma_req_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .txEmpty       (txEmpty),
    .rxAvail       (rxAvail),
    .txReqEn       (txReqEn),
    .rxReqEn       (rxReqEn),
    .firstCharMode (firstCharMode),
    .specialCond   (specialCond),
    .txRdyN        (txRdyN),
    .rxRdyN        (rxRdyN),
    .strobe        (strobe)
  );

  dma_req_datapath #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxIntClr (rxIntClr),
    .txRdyN   (txRdyN),
    .rxRdyN   (rxRdyN),
    .rxIntReq (rxIntReq)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (rstN || (&txRdyN && &rxRdyN && rxIntReq == '0))) else $error("reset state"); // R1

endmodule

// File: tb/dma_req_pulse_gen_tb_top.sv
module dma_req_pulse_gen_tb_top;
  localparam int NCH = 2;
  localparam int PL  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [NCH-1:0] txEmpty, rxAvail, txReqEn, rxReqEn, firstCharMode, specialCond, rxIntClr;
  logic [NCH-1:0] txRdyN, rxRdyN, rxIntReq;

  int checks = 0;
  int fails  = 0;

  dma_req_pulse_gen #(.NUM_CH(NCH), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .rxAvail(rxAvail),
    .txReqEn(txReqEn), .rxReqEn(rxReqEn), .firstCharMode(firstCharMode),
    .specialCond(specialCond), .rxIntClr(rxIntClr),
    .txRdyN(txRdyN), .rxRdyN(rxRdyN), .rxIntReq(rxIntReq)
  );

  task automatic check(input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic quiesce;
    txEmpty = '0; rxAvail = '0; specialCond = '0; firstCharMode = '0;
    rxIntClr = '1;
    step;
    rxIntClr = '0;
    step;
  endtask

  // One rising edge on one channel under a given configuration
  task automatic pulseTrial(input bit isRx, input int ch, input bit en,
                            input bit mode, input bit spec);
    logic [NCH-1:0] bitM;
    bit expPulse, expInt;
    string req;
    bitM = NCH'(1) << ch;
    quiesce;
    txReqEn = '1; rxReqEn = '1;
    if (!en) begin
      if (isRx) rxReqEn = ~bitM; else txReqEn = ~bitM;
    end
    firstCharMode = mode ? bitM : '0;
    specialCond   = spec ? bitM : '0;
    expInt   = isRx && mode && spec;
    expPulse = en && !expInt;
    if (!isRx) req = "R2";
    else if (expInt) req = "R7";
    else if (spec) req = "R8";
    else req = "R3";
    if (!en && !expInt) req = "R4";
    if (isRx) rxAvail = bitM; else txEmpty = bitM;
    step;
    for (int j = 0; j < PL + 3; j++) begin
      logic [NCH-1:0] expOut;
      string r;
      expOut = (expPulse && j < PL) ? ~bitM : '1;
      r = (j >= PL) ? "R5" : req;
      check(r, isRx ? "rxRdyN" : "txRdyN", isRx ? rxRdyN : txRdyN, expOut);
      check("R10", isRx ? "txRdyN idle" : "rxRdyN idle", isRx ? txRdyN : rxRdyN, '1);
      check(expInt ? "R7" : "R8", "rxIntReq", rxIntReq, expInt ? bitM : '0);
      step;
    end
    txEmpty = '0; rxAvail = '0;
  endtask

  // Drop and raise the condition g cycles into a pulse
  task automatic retrigger(input bit isRx, input int ch, input int g);
    logic [NCH-1:0] bitM;
    bitM = NCH'(1) << ch;
    quiesce;
    txReqEn = '1; rxReqEn = '1;
    if (isRx) rxAvail = bitM; else txEmpty = bitM;
    step;
    for (int j = 0; j <= g + PL + 1; j++) begin
      bit low;
      low = (j < PL) || (g >= PL && j >= g + 1 && j <= g + PL);
      check("R6", isRx ? "rxRdyN retrig" : "txRdyN retrig",
            isRx ? rxRdyN : txRdyN, low ? ~bitM : '1);
      if (j == 0) begin
        if (isRx) rxAvail = '0; else txEmpty = '0;
      end
      if (j == g) begin
        if (isRx) rxAvail = bitM; else txEmpty = bitM;
      end
      step;
    end
    txEmpty = '0; rxAvail = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    txEmpty = '0; rxAvail = '0; txReqEn = '0; rxReqEn = '0;
    firstCharMode = '0; specialCond = '0; rxIntClr = '0;
    @(negedge clk); @(negedge clk);
    check("R1", "txRdyN in reset", txRdyN, '1);
    check("R1", "rxIntReq in reset", rxIntReq, '0);
    rstN = 1'b1;
    step;
    check("R1", "txRdyN after reset", txRdyN, '1);
    check("R1", "rxRdyN after reset", rxRdyN, '1);
    check("R1", "rxIntReq after reset", rxIntReq, '0);

    // Sweep of every channel, direction, enable, mode and special flag
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 16; k++)
        pulseTrial(k[3], ch, k[2], k[1], k[0]);

    // Retrigger offsets inside and just past the pulse
    for (int ch = 0; ch < NCH; ch++)
      for (int d = 0; d < 2; d++)
        for (int g = 1; g <= PL + 1; g++)
          retrigger(d[0], ch, g);

    // R10: two channels pulse together
    quiesce;
    txReqEn = '1; rxReqEn = '1;
    txEmpty = 2'b01; rxAvail = 2'b10;
    step;
    for (int j = 0; j < PL + 1; j++) begin
      check("R10", "txRdyN concurrent", txRdyN, (j < PL) ? 2'b10 : 2'b11);
      check("R10", "rxRdyN concurrent", rxRdyN, (j < PL) ? 2'b01 : 2'b11);
      step;
    end

    // R9: sticky interrupt, set beats clear, clear alone drops it
    quiesce;
    rxReqEn = '1;
    firstCharMode = 2'b10; specialCond = 2'b10;
    rxAvail = 2'b10;
    step;
    for (int j = 0; j < 3; j++) begin
      check("R9", "rxIntReq held", rxIntReq, 2'b10);
      step;
    end
    rxAvail = '0;
    step;
    rxAvail = 2'b10; rxIntClr = 2'b10;
    step;
    check("R9", "rxIntReq set over clear", rxIntReq, 2'b10);
    rxAvail = 2'b10; rxIntClr = 2'b10;
    step;
    check("R9", "rxIntReq cleared", rxIntReq, 2'b00);
    rxIntClr = '0;
    step;
    check("R9", "rxIntReq stays clear", rxIntReq, 2'b00);
    check("R7", "rxRdyN during diversion", rxRdyN, 2'b11);

    finishRun();
  end

endmodule